// File: doc/BRIEF.md
# Two-Phase Pixel Bus Demultiplexer

This block takes pixels that arrive as two successive half-words on a 12-bit bus and rebuilds 24-bit pixels. Each rebuilt pixel leaves through one output register together with the horizontal and vertical sync that came with it and a one-cycle valid strobe. A source may send one half per clock edge, with the bus clock at the pixel rate. Or it may send one half per clock period on a single chosen edge, with the bus clock at twice the pixel rate.

Three static configuration pins set the capture. `mode_dual` picks dual-edge or single-edge transfer. `edge_sel` picks the capture edge in single-edge transfer, or the edge that takes the first half in dual-edge transfer. `clk_inv` reverses the clock sense before the edge choice applies. Configuration pins are changed only while reset is held. Syncs are active high. All outputs change only on the rising edge of `clk`.

Top module: `pix_demux`

## Requirements
- R1: The first half of a pixel lands on `pix_out[23:12]` and the second half on `pix_out[11:0]`. Pixels leave in the order they arrived.
- R2: The effective edge is `edge_sel ^ clk_inv`. A value of 0 means the rising edge of `clk` and a value of 1 means the falling edge.
- R3: With `mode_dual`=0, one half is taken on each effective edge. `pix_valid` pulses for one cycle per two halves, so it is never high on two consecutive cycles.
- R4: With `mode_dual`=1, the first half is taken on the effective edge and the second half on the opposite edge. Once the first pixel is complete, `pix_valid` stays high on every cycle.
- R5: With `mode_dual`=0, a half that carries a rising `hsync_in` (low on the previous capture, high on this one) is always treated as a first half. A misaligned phase is corrected at the start of each line.
- R6: `hsync_out` and `vsync_out` carry the sync levels captured with the first half of the pixel on `pix_out`. They change only when `pix_valid` is high.
- R7: While `rst_n` is low, `pix_valid`, `pix_out`, `hsync_out` and `vsync_out` are 0, and the phase and the held first half are cleared. Reset acts asynchronously.
- R8: `pix_out` holds its value on every cycle where `pix_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, at the pixel rate or twice the pixel rate |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released synchronously upstream |
| mode_dual | input | 1 | 1: dual-edge transfer, 0: single-edge transfer |
| edge_sel | input | 1 | Capture edge (single-edge) or first-half edge (dual-edge), 0 = rising |
| clk_inv | input | 1 | Reverses clock sense before the edge choice |
| din | input | 12 | Half-pixel data bus |
| hsync_in | input | 1 | Horizontal sync from the source, active high |
| vsync_in | input | 1 | Vertical sync from the source, active high |
| pix_out | output | 24 | Rebuilt pixel, first half in the upper bits |
| pix_valid | output | 1 | One-cycle strobe marking a new pixel on `pix_out` |
| hsync_out | output | 1 | Horizontal sync aligned to `pix_out` |
| vsync_out | output | 1 | Vertical sync aligned to `pix_out` |

## Verification
The cycle-level checks hold on every clock. In single-edge transfer the strobe never repeats on back-to-back cycles. In dual-edge transfer it never drops once it has started. Pixel and sync outputs stay frozen between strobes, and reset clears the outputs. Only the bench scenarios can show that the right half lands in the right place for each of the eight mode, edge and polarity combinations. The same holds for correct line realignment after an odd number of stray halves, and for syncs staying tied to the right pixel. These need a known pixel stream compared in order.

// File: rtl/pxd_pkg.sv
package pxd_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  parameter int unsigned PXD_HALF_W = 12;

  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } phase_e;
endpackage

// File: rtl/pxd_edge_capture.sv
module pxd_edge_capture #(
  parameter int unsigned SLOT_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot_in,
  output logic [SLOT_W-1:0] rise_q,
  output logic [SLOT_W-1:0] fall_q
);
  timeunit 1ns;
  timeprecision 100ps;

  // slot sampled on the rising edge of clk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= '0;
    else        rise_q <= slot_in;
  end

  // slot sampled on the falling edge of clk
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= slot_in;
  end
endmodule

// File: rtl/pxd_half_select.sv
module pxd_half_select #(
  parameter int unsigned HALF_W = 12
) (
  input  logic                eff_fall,
  input  logic [HALF_W+1:0]   live_slot,
  input  logic [HALF_W+1:0]   rise_q,
  input  logic [HALF_W+1:0]   fall_q,
  output logic [HALF_W+1:0]   sdr_slot,
  output logic [HALF_W+1:0]   first_slot,
  output logic [HALF_W-1:0]   second_data
);
  timeunit 1ns;
  timeprecision 100ps;

  // Everything is consumed on the rising edge of clk.
  // Falling-edge captures arrive through fall_q, rising-edge captures
  // are either the live bus (this edge) or rise_q (previous edge).
  always_comb begin
    if (eff_fall) begin
      sdr_slot    = fall_q;
      first_slot  = fall_q;
      second_data = live_slot[HALF_W-1:0];
    end else begin
      sdr_slot    = live_slot;
      first_slot  = rise_q;
      second_data = fall_q[HALF_W-1:0];
    end
  end
endmodule

// File: rtl/pxd_sdr_assembler.sv
module pxd_sdr_assembler
  import pxd_pkg::*;
#(
  parameter int unsigned HALF_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [HALF_W+1:0]     cur_slot,
  output logic                  done,
  output logic [2*HALF_W-1:0]   pix,
  output logic                  hs,
  output logic                  vs
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int unsigned SLOT_W = HALF_W + 2;
  localparam int unsigned VS_BIT = HALF_W;
  localparam int unsigned HS_BIT = HALF_W + 1;

  phase_e              phase_q, phase_d;
  logic [SLOT_W-1:0]   held_q, held_d;
  logic                hs_prev_q;
  logic                hs_rise;
  logic                take_first;

  always_comb begin
    hs_rise    = cur_slot[HS_BIT] & ~hs_prev_q;
    take_first = hs_rise | (phase_q == PH_FIRST);
    phase_d    = take_first ? PH_SECOND : PH_FIRST;
    held_d     = take_first ? cur_slot : held_q;
    done       = en & ~take_first;
    pix        = {held_q[HALF_W-1:0], cur_slot[HALF_W-1:0]};
    hs         = held_q[HS_BIT];
    vs         = held_q[VS_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_FIRST;
      held_q    <= '0;
      hs_prev_q <= 1'b0;
    end else if (en) begin
      phase_q   <= phase_d;
      held_q    <= held_d;
      hs_prev_q <= cur_slot[HS_BIT];
    end
  end
endmodule

// File: rtl/pxd_ddr_assembler.sv
module pxd_ddr_assembler #(
  parameter int unsigned HALF_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [HALF_W+1:0]     first_slot,
  input  logic [HALF_W-1:0]     second_data,
  output logic                  done,
  output logic [2*HALF_W-1:0]   pix,
  output logic                  hs,
  output logic                  vs
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int unsigned VS_BIT = HALF_W;
  localparam int unsigned HS_BIT = HALF_W + 1;

  logic primed_q, primed_d;

  always_comb begin
    primed_d = primed_q | en;
    done     = en & primed_q;
    pix      = {first_slot[HALF_W-1:0], second_data};
    hs       = first_slot[HS_BIT];
    vs       = first_slot[VS_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  primed_q <= 1'b0;
    else if (en) primed_q <= primed_d;
  end
endmodule

// File: rtl/pix_demux.sv
module pix_demux
  import pxd_pkg::*;
#(
  parameter int unsigned HALF_W = PXD_HALF_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_dual,
  input  logic                  edge_sel,
  input  logic                  clk_inv,
  input  logic [HALF_W-1:0]     din,
  input  logic                  hsync_in,
  input  logic                  vsync_in,
  output logic [2*HALF_W-1:0]   pix_out,
  output logic                  pix_valid,
  output logic                  hsync_out,
  output logic                  vsync_out
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int unsigned SLOT_W = HALF_W + 2;
  localparam int unsigned PIX_W  = 2 * HALF_W;

  logic                eff_fall;
  logic [SLOT_W-1:0]   live_slot, rise_q, fall_q;
  logic [SLOT_W-1:0]   sdr_slot, first_slot;
  logic [HALF_W-1:0]   second_data;

  logic                sdr_done, ddr_done;
  logic [PIX_W-1:0]    sdr_pix, ddr_pix;
  logic                sdr_hs, sdr_vs, ddr_hs, ddr_vs;

  logic                valid_d;
  logic [PIX_W-1:0]    pix_d;
  logic                hs_d, vs_d;

  assign eff_fall  = edge_sel ^ clk_inv;
  assign live_slot = {hsync_in, vsync_in, din};

  pxd_edge_capture #(.SLOT_W(SLOT_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .slot_in (live_slot),
    .rise_q  (rise_q),
    .fall_q  (fall_q)
  );

  pxd_half_select #(.HALF_W(HALF_W)) u_sel (
    .eff_fall    (eff_fall),
    .live_slot   (live_slot),
    .rise_q      (rise_q),
    .fall_q      (fall_q),
    .sdr_slot    (sdr_slot),
    .first_slot  (first_slot),
    .second_data (second_data)
  );

  pxd_sdr_assembler #(.HALF_W(HALF_W)) u_sdr (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (~mode_dual),
    .cur_slot (sdr_slot),
    .done     (sdr_done),
    .pix      (sdr_pix),
    .hs       (sdr_hs),
    .vs       (sdr_vs)
  );

  pxd_ddr_assembler #(.HALF_W(HALF_W)) u_ddr (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (mode_dual),
    .first_slot  (first_slot),
    .second_data (second_data),
    .done        (ddr_done),
    .pix         (ddr_pix),
    .hs          (ddr_hs),
    .vs          (ddr_vs)
  );

  always_comb begin
    valid_d = mode_dual ? ddr_done : sdr_done;
    pix_d   = mode_dual ? ddr_pix  : sdr_pix;
    hs_d    = mode_dual ? ddr_hs   : sdr_hs;
    vs_d    = mode_dual ? ddr_vs   : sdr_vs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_valid <= 1'b0;
    else        pix_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_out   <= '0;
      hsync_out <= 1'b0;
      vsync_out <= 1'b0;
    end else if (valid_d) begin
      pix_out   <= pix_d;
      hsync_out <= hs_d;
      vsync_out <= vs_d;
    end
  end
endmodule

// File: rtl/pxd_checks.sv
module pxd_checks #(
  parameter int unsigned PIX_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_dual,
  input logic [PIX_W-1:0] pix_out,
  input logic             pix_valid,
  input logic             hsync_out,
  input logic             vsync_out
);
  timeunit 1ns;
  timeprecision 100ps;

  p_sdr_spaced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_dual && pix_valid) |=> !pix_valid);

  p_ddr_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_dual && pix_valid) |=> pix_valid);

  p_sync_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> ($stable(hsync_out) && $stable(vsync_out)));

  p_pix_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> $stable(pix_out));

  p_reset_clear_r7: assert property (@(posedge clk)
    !rst_n |-> (!pix_valid && pix_out == '0 && !hsync_out && !vsync_out));
endmodule

bind pix_demux pxd_checks #(.PIX_W(2*HALF_W)) u_pxd_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_dual (mode_dual),
  .pix_out   (pix_out),
  .pix_valid (pix_valid),
  .hsync_out (hsync_out),
  .vsync_out (vsync_out)
);

// File: tb/test_pix_demux.sv
module test_pix_demux;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NPIX = 16;
  // {mode_dual, edge_sel, clk_inv}
  localparam logic [2:0] CFG_TAB [0:7] = '{
    3'b000, 3'b010, 3'b001, 3'b011,
    3'b100, 3'b110, 3'b101, 3'b111
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_dual, edge_sel, clk_inv;
  logic [11:0] din;
  logic        hsync_in, vsync_in;
  logic [23:0] pix_out;
  logic        pix_valid, hsync_out, vsync_out;

  int          n_cmp = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;
  bit          mon_en = 1'b0;
  bit          started;
  bit          cur_dual;
  int          idx;
  logic [11:0] cur_base;

  always #2 clk = ~clk;

  pix_demux i_pix_demux (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_dual (mode_dual),
    .edge_sel  (edge_sel),
    .clk_inv   (clk_inv),
    .din       (din),
    .hsync_in  (hsync_in),
    .vsync_in  (vsync_in),
    .pix_out   (pix_out),
    .pix_valid (pix_valid),
    .hsync_out (hsync_out),
    .vsync_out (vsync_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] hi_of(input int i, input logic [11:0] b);
    return 12'(int'(b) + i * 37);
  endfunction

  function automatic logic [11:0] lo_of(input int i, input logic [11:0] b);
    return 12'(int'(b) * 3 + i * 91 + 5);
  endfunction

  // Output monitor: compares the stream in order, starting at the line start
  always @(negedge clk) begin
    if (mon_en && pix_valid) begin
      if (!started && hsync_out) started = 1'b1;
      if (started && idx < NPIX) begin
        chk(pix_out == {hi_of(idx, cur_base), lo_of(idx, cur_base)},
            cur_dual ? "R1 R2 R4 pixel" : "R1 R2 R3 R5 pixel",
            32'(pix_out), 32'({hi_of(idx, cur_base), lo_of(idx, cur_base)}));
        chk(hsync_out == (idx == 0) && vsync_out == (idx == 1 || idx == 2),
            "R6 sync alignment", 32'({hsync_out, vsync_out}),
            32'({idx == 0, idx == 1 || idx == 2}));
        idx++;
      end
    end
  end

  task automatic drive_half(input logic [11:0] d, input logic h, input logic v);
    din = d; hsync_in = h; vsync_in = v;
  endtask

  task automatic run_cfg(input logic [2:0] cfg, input logic [11:0] base);
    bit eff;
    int step;
    int junk;
    int cnt;
    rst_n = 1'b0;
    {mode_dual, edge_sel, clk_inv} = cfg;
    drive_half(12'h000, 1'b0, 1'b0);
    @(negedge clk); #1;
    chk(!pix_valid && pix_out == 24'h0 && !hsync_out && !vsync_out, "R7 reset state",
        32'({pix_valid, hsync_out, vsync_out, pix_out}), 32'h0);
    rst_n = 1'b1;
    started = 1'b0; idx = 0; cur_base = base; cur_dual = mode_dual; mon_en = 1'b1;
    repeat (3) @(posedge clk);
    eff  = edge_sel ^ clk_inv;   // R2: 1 selects the falling edge
    step = mode_dual ? 2 : 4;
    junk = mode_dual ? 2 : 3;    // odd stray halves in single-edge: R5
    if (eff) begin @(posedge clk); #1; end
    else     begin @(negedge clk); #1; end
    for (int j = 0; j < junk; j++) begin
      drive_half(12'hA5C ^ 12'(j), 1'b0, 1'b0);
      #(step);
    end
    for (int i = 0; i < NPIX; i++) begin
      drive_half(hi_of(i, base), i == 0, i == 1 || i == 2);
      #(step);
      drive_half(lo_of(i, base), i == 0, i == 1 || i == 2);
      #(step);
    end
    drive_half(12'h000, 1'b0, 1'b0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(idx == NPIX, "R2 R5 full line received", 32'(idx), 32'(NPIX));
    cnt = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (pix_valid) cnt++;
    end
    chk(cnt == (mode_dual ? 8 : 4), mode_dual ? "R4 strobe rate" : "R3 strobe rate",
        32'(cnt), 32'(mode_dual ? 8 : 4));
    mon_en = 1'b0;
  endtask

  initial begin
    logic [23:0] held;
    rst_n = 1'b0;
    mode_dual = 1'b0; edge_sel = 1'b0; clk_inv = 1'b0;
    drive_half(12'h000, 1'b0, 1'b0);
    #1;
    chk(!pix_valid && pix_out == 24'h0, "R7 power-on reset",
        32'({pix_valid, pix_out}), 32'h0);

    for (int k = 0; k < 8; k++) run_cfg(CFG_TAB[k], 12'(k * 256 + 17));

    // R8: between strobes in single-edge mode the pixel stays put
    run_cfg(3'b000, 12'h3C1);
    @(negedge clk);
    while (!pix_valid) @(negedge clk);
    held = pix_out;
    @(negedge clk);
    chk(!pix_valid && pix_out == held, "R8 hold between strobes", 32'(pix_out), 32'(held));

    // R7: reset in the middle of a dual-edge stream clears the outputs at once
    run_cfg(3'b100, 12'h7E2);
    drive_half(12'hFFF, 1'b1, 1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    rst_n = 1'b0;
    #0.5;
    chk(!pix_valid && pix_out == 24'h0 && !hsync_out && !vsync_out, "R7 mid-stream reset",
        32'({pix_valid, hsync_out, vsync_out, pix_out}), 32'h0);
    rst_n = 1'b1;

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule